// File: doc/BRIEF.md
# Pixel Memory Access Unit

This block sits between the command side of a monochrome graphic display controller and its pixel memory. The memory holds 65 lines of 160 pixels each, one bit per pixel. The processor side reaches it one byte at a time. A byte covers eight vertically stacked pixels of one page at one column. A 4-bit page register chooses the page. An 8-bit column counter, separate from the page register, chooses the column and steps forward by itself after each data access. That lets a host stream a whole page row with one address setup.

Pages 0 to 7 are full eight-line pages. Page 8 is a single-line icon page, and only bit 0 of the byte is stored there. When the column counter moves past the last real column it locks, and further accesses do nothing until the column is set again. A separate scan port returns one whole pixel line per request for the panel refresh engine. A direction bit mirrors the column order on that port without changing how the host addresses the memory.

Top module: `dram_access_unit`

## Requirements
- R1: After reset the page is 0, the column is 0, the lock is clear, the mirror bit is 0, `rd_valid` is 0 and every pixel reads 0.
- R2: A command with `cmd_valid` high and `cmd_op` 3'd0 loads the page from `cmd_arg`. Op 3'd1 loads the column from all 8 bits of `cmd_arg`. Neither changes the other register. Ops 3'd5 to 3'd7 change nothing.
- R3: Op 3'd2 writes `cmd_arg` at the current page P (0 to 7) and column C. Bit k of the byte goes to pixel line 8*P+k at column C, so bit 0 is the lowest line of the page.
- R4: On page 8 only bit 0 is kept, in line 64. A read of page 8 returns 0 in bits 7 to 1.
- R5: Op 3'd3 puts the byte at the current page and column on `rd_data`, with `rd_valid` high, on the clock edge after the command. `rd_valid` is low after any cycle without a read, and `rd_data` holds its value until the next read.
- R6: Every write or read made while the column is below 160 raises the column by exactly one, after the access.
- R7: A column of 160 or more is locked: `col_locked` is 1, accesses leave the column unchanged, writes store nothing and reads return 0. Only op 3'd1 releases the lock.
- R8: An op 3'd0 whose `cmd_arg` exceeds 8 is ignored and the page keeps its value.
- R9: Op 3'd4 sets the mirror bit from `cmd_arg[0]`. With mirror 0, `scan_row[s]` is column s. With mirror 1, it is column 159-s. Host-side addressing is the same in both cases.
- R10: `scan_row` shows line `scan_line` one clock edge after that line is presented. Lines 65 and above read as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code (0 page, 1 column, 2 write, 3 read, 4 direction) |
| cmd_arg | input | 8 | Page, column, write byte or direction bit |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | High for the one cycle after a read command |
| page_o | output | 4 | Current page register |
| col_o | output | 8 | Current column counter |
| col_locked | output | 1 | Column counter is past the last real column |
| mirror_o | output | 1 | Current column direction |
| scan_line | input | 7 | Pixel line requested by the scan engine |
| scan_row | output | 160 | Requested line in segment order |

## Verification
The checker follows the counter and register rules on every cycle. These are the single-step increment, the frozen column while locked, page loads rejected when out of range, column loads that leave the page alone, the one-cycle read strobe and the direction bit load. Only the bench scenarios can show where bytes land and what they read back as. They cover the bit-to-line order within a page, icon-page truncation, writes dropped while locked, zeros read at a locked column, and the mirrored segment order. For that the bench fills every column of every page, then sweeps all 65 lines through the scan port and compares them with an arithmetic pattern.

// File: rtl/dram_pkg.sv
package dram_pkg;
   typedef enum logic [2:0] {
      OP_PAGE  = 3'd0,
      OP_COL   = 3'd1,
      OP_WRITE = 3'd2,
      OP_READ  = 3'd3,
      OP_DIR   = 3'd4
   } dram_op_e;
endpackage

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
   import dram_pkg::*;
#(
   parameter int COLS     = 160,
   parameter int COL_W    = 8,
   parameter int PAGE_W   = 4,
   parameter int ARG_W    = 8,
   parameter int MAX_PAGE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ARG_W-1:0]  cmd_arg,
   output logic [PAGE_W-1:0] page_q,
   output logic [COL_W-1:0]  col_q,
   output logic              mirror_q,
   output logic              locked,
   output logic              wr_en,
   output logic              rd_en
);
   localparam logic [COL_W-1:0] COL_END  = COL_W'(COLS);
   localparam logic [ARG_W-1:0] PAGE_TOP = ARG_W'(MAX_PAGE);

   logic is_page, is_col, is_dir, access;

   always_comb begin
      is_page = cmd_valid && (cmd_op == OP_PAGE);
      is_col  = cmd_valid && (cmd_op == OP_COL);
      is_dir  = cmd_valid && (cmd_op == OP_DIR);
      wr_en   = cmd_valid && (cmd_op == OP_WRITE);
      rd_en   = cmd_valid && (cmd_op == OP_READ);
      access  = wr_en || rd_en;
      locked  = (col_q >= COL_END);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (is_page && (cmd_arg <= PAGE_TOP)) begin
         page_q <= PAGE_W'(cmd_arg);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
      end else if (is_col) begin
         col_q <= COL_W'(cmd_arg);
      end else if (access && !locked) begin
         col_q <= col_q + COL_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mirror_q <= 1'b0;
      end else if (is_dir) begin
         mirror_q <= cmd_arg[0];
      end
   end
endmodule

// File: rtl/dram_store.sv
module dram_store #(
   parameter int COLS   = 160,
   parameter int LINES  = 65,
   parameter int DATA_W = 8,
   parameter int COL_W  = 8,
   parameter int PAGE_W = 4,
   parameter int LINE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] page,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LINE_W-1:0] scan_line,
   output logic [DATA_W-1:0] rd_byte,
   output logic [COLS-1:0]   scan_bits
);
   localparam logic [COL_W-1:0] COL_END = COL_W'(COLS);

   logic [LINES-1:0][COLS-1:0] lines;
   logic col_ok;

   assign col_ok = (col < COL_END);

   for (genvar l = 0; l < LINES; l++) begin : g_line
      localparam int PG = l / DATA_W;
      localparam int BT = l % DATA_W;
      logic [COLS-1:0] row;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row <= '0;
         end else if (wr_en && col_ok && (page == PAGE_W'(PG))) begin
            row[col] <= wr_data[BT];
         end
      end
      assign lines[l] = row;
   end

   always_comb begin
      rd_byte = '0;
      for (int k = 0; k < DATA_W; k++) begin
         int idx;
         idx = int'(page) * DATA_W + k;
         if (col_ok && (idx < LINES)) begin
            rd_byte[k] = lines[idx][col];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_bits <= '0;
      end else if (int'(scan_line) < LINES) begin
         scan_bits <= lines[scan_line];
      end else begin
         scan_bits <= '0;
      end
   end
endmodule

// File: rtl/dram_seg_map.sv
module dram_seg_map #(
   parameter int COLS      = 160,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic [COLS-1:0] col_bits,
   input  logic            mirror,
   output logic [COLS-1:0] seg_bits
);
   if (MIRROR_EN) begin : g_mirror
      for (genvar s = 0; s < COLS; s++) begin : g_seg
         assign seg_bits[s] = mirror ? col_bits[COLS-1-s] : col_bits[s];
      end
   end else begin : g_straight
      logic unused_mirror;
      assign unused_mirror = mirror;
      assign seg_bits = col_bits;
   end
endmodule

// File: rtl/dram_access_unit.sv
module dram_access_unit #(
   parameter int COLS       = 160,
   parameter int DATA_PAGES = 8,
   parameter int DATA_W     = 8,
   parameter int ICON_LINES = 1,
   parameter int COL_W      = 8,
   parameter int PAGE_W     = 4,
   parameter int ARG_W      = 8
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              cmd_valid,
   input  logic [2:0]                                        cmd_op,
   input  logic [ARG_W-1:0]                                  cmd_arg,
   output logic [DATA_W-1:0]                                 rd_data,
   output logic                                              rd_valid,
   output logic [PAGE_W-1:0]                                 page_o,
   output logic [COL_W-1:0]                                  col_o,
   output logic                                              col_locked,
   output logic                                              mirror_o,
   input  logic [$clog2(DATA_PAGES*DATA_W+ICON_LINES)-1:0]   scan_line,
   output logic [COLS-1:0]                                   scan_row
);
   localparam int LINES    = DATA_PAGES * DATA_W + ICON_LINES;
   localparam int LINE_W   = $clog2(LINES);
   localparam int MAX_PAGE = (ICON_LINES > 0) ? DATA_PAGES : DATA_PAGES - 1;

   if (COLS >= (1 << COL_W)) begin : g_bad_cols
      $error("column counter too narrow to reach the lock value");
   end
   if (MAX_PAGE >= (1 << PAGE_W)) begin : g_bad_page
      $error("page register too narrow for page count");
   end
   if ((COL_W > ARG_W) || (DATA_W > ARG_W)) begin : g_bad_arg
      $error("command argument narrower than column or data");
   end
   if ((ICON_LINES < 0) || (ICON_LINES >= DATA_W)) begin : g_bad_icon
      $error("icon line count must fit in one partial page");
   end

   logic [DATA_W-1:0] rd_byte;
   logic [COLS-1:0]   scan_bits;
   logic              wr_en, rd_en;

   dram_addr_ctrl #(
      .COLS(COLS), .COL_W(COL_W), .PAGE_W(PAGE_W),
      .ARG_W(ARG_W), .MAX_PAGE(MAX_PAGE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
      .page_q(page_o), .col_q(col_o), .mirror_q(mirror_o),
      .locked(col_locked), .wr_en(wr_en), .rd_en(rd_en)
   );

   dram_store #(
      .COLS(COLS), .LINES(LINES), .DATA_W(DATA_W),
      .COL_W(COL_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .page(page_o), .col(col_o),
      .wr_data(cmd_arg[DATA_W-1:0]), .scan_line(scan_line),
      .rd_byte(rd_byte), .scan_bits(scan_bits)
   );

   dram_seg_map #(.COLS(COLS), .MIRROR_EN(1'b1)) u_map (
      .col_bits(scan_bits), .mirror(mirror_o), .seg_bits(scan_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= rd_byte;
      end
   end
endmodule

// File: rtl/dram_access_unit_chk.sv
module dram_access_unit_chk #(
   parameter int COLS     = 160,
   parameter int COL_W    = 8,
   parameter int PAGE_W   = 4,
   parameter int ARG_W    = 8,
   parameter int MAX_PAGE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [ARG_W-1:0]  cmd_arg,
   input logic [PAGE_W-1:0] page_o,
   input logic [COL_W-1:0]  col_o,
   input logic              col_locked,
   input logic              mirror_o,
   input logic              rd_valid
);
   logic acc, rd_cmd;
   assign acc    = cmd_valid && ((cmd_op == 3'd2) || (cmd_op == 3'd3));
   assign rd_cmd = cmd_valid && (cmd_op == 3'd3);

   // R6
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !col_locked) |=> (col_o == $past(col_o) + COL_W'(1)));

   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && col_locked) |=> ($stable(col_o) && col_locked));

   // R8
   page_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd0) && (cmd_arg > ARG_W'(MAX_PAGE))) |=> $stable(page_o));

   // R2
   col_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd1)) |=> ((col_o == COL_W'($past(cmd_arg))) && $stable(page_o)));

   // R5
   rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> rd_valid);

   // R5
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cmd |=> !rd_valid);

   // R9
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd4)) |=> (mirror_o == $past(cmd_arg[0])));
endmodule

bind dram_access_unit dram_access_unit_chk #(
   .COLS(COLS), .COL_W(COL_W), .PAGE_W(PAGE_W),
   .ARG_W(ARG_W), .MAX_PAGE(MAX_PAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_arg(cmd_arg), .page_o(page_o), .col_o(col_o),
   .col_locked(col_locked), .mirror_o(mirror_o), .rd_valid(rd_valid)
);

// File: tb/dram_access_unit_test.sv
module dram_access_unit_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [2:0]   cmd_op = '0;
   logic [7:0]   cmd_arg = '0;
   logic [7:0]   rd_data;
   logic         rd_valid;
   logic [3:0]   page_o;
   logic [7:0]   col_o;
   logic         col_locked;
   logic         mirror_o;
   logic [6:0]   scan_line = '0;
   logic [159:0] scan_row;

   int total = 0;
   int bad = 0;
   logic [7:0] model [9][160];

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_access_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .rd_data(rd_data), .rd_valid(rd_valid),
      .page_o(page_o), .col_o(col_o), .col_locked(col_locked),
      .mirror_o(mirror_o), .scan_line(scan_line), .scan_row(scan_row)
   );

   task automatic chk(input string req, input string what,
                      input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] arg);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_arg   = arg;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   function automatic logic [7:0] pat(int p, int c);
      return 8'((p * 53 + c * 7 + 3) & 255);
   endfunction

   function automatic logic [159:0] exp_row(int line, bit mir);
      logic [159:0] r;
      r = '0;
      if (line < 65) begin
         for (int s = 0; s < 160; s++) begin
            int c;
            c = mir ? 159 - s : s;
            r[s] = model[line / 8][c][line % 8];
         end
      end
      return r;
   endfunction

   task automatic scan_chk(input string req, input int line, input bit mir);
      scan_line = 7'(line);
      @(negedge clk);
      chk(req, $sformatf("scan line %0d", line), scan_row, exp_row(line, mir));
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < 9; p++)
         for (int c = 0; c < 160; c++) model[p][c] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "page", 160'(page_o), 160'd0);
      chk("R1", "col", 160'(col_o), 160'd0);
      chk("R1", "locked", 160'(col_locked), 160'd0);
      chk("R1", "mirror", 160'(mirror_o), 160'd0);
      chk("R1", "rd_valid", 160'(rd_valid), 160'd0);
      rst_n = 1'b1;
      @(negedge clk);
      scan_chk("R1", 0, 1'b0);

      // R3 R4 R6 fill every page, streaming with auto-increment
      for (int p = 0; p < 9; p++) begin
         issue(3'd0, 8'(p));
         chk("R2", "page load", 160'(page_o), 160'(p));
         issue(3'd1, 8'd0);
         for (int c = 0; c < 160; c++) begin
            issue(3'd2, pat(p, c));
            model[p][c] = (p == 8) ? {7'd0, pat(p, c)[0]} : pat(p, c);
            chk("R6", "col after write", 160'(col_o), 160'(c + 1));
         end
         chk("R7", "locked at end", 160'(col_locked), 160'd1);
      end
      // R7 writes while locked store nothing and keep column
      issue(3'd2, 8'hFF);
      issue(3'd2, 8'hFF);
      chk("R7", "col frozen", 160'(col_o), 160'd160);

      for (int l = 0; l < 64; l++) scan_chk("R3", l, 1'b0);
      scan_chk("R4", 64, 1'b0);
      // R10 out-of-range lines
      scan_chk("R10", 70, 1'b0);
      scan_chk("R10", 127, 1'b0);

      // R5 read back page 3
      issue(3'd0, 8'd3);
      issue(3'd1, 8'd0);
      for (int c = 0; c < 160; c++) begin
         issue(3'd3, 8'h00);
         chk("R5", "rd_valid", 160'(rd_valid), 160'd1);
         chk("R5", $sformatf("rd_data col %0d", c), 160'(rd_data), 160'(model[3][c]));
         chk("R6", "col after read", 160'(col_o), 160'(c + 1));
      end
      @(negedge clk);
      chk("R5", "rd_valid drops", 160'(rd_valid), 160'd0);
      chk("R5", "rd_data holds", 160'(rd_data), 160'(model[3][159]));
      // R7 read at locked column
      issue(3'd3, 8'h00);
      chk("R7", "locked read", 160'(rd_data), 160'd0);
      chk("R7", "locked read col", 160'(col_o), 160'd160);

      // R4 icon page read
      issue(3'd0, 8'd8);
      issue(3'd1, 8'd5);
      issue(3'd3, 8'h00);
      chk("R4", "icon read", 160'(rd_data), 160'({7'd0, pat(8, 5)[0]}));

      // R8 out-of-range page values
      issue(3'd0, 8'd5);
      issue(3'd0, 8'd9);
      chk("R8", "page 9 ignored", 160'(page_o), 160'd5);
      issue(3'd0, 8'hF0);
      chk("R8", "page F0 ignored", 160'(page_o), 160'd5);

      // R7 set column beyond end, then release
      issue(3'd1, 8'd200);
      chk("R7", "col 200", 160'(col_o), 160'd200);
      chk("R7", "locked 200", 160'(col_locked), 160'd1);
      issue(3'd2, 8'hAA);
      chk("R7", "col 200 frozen", 160'(col_o), 160'd200);
      issue(3'd1, 8'd159);
      chk("R7", "released", 160'(col_locked), 160'd0);
      issue(3'd2, 8'h5A);
      model[5][159] = 8'h5A;
      chk("R7", "relock", 160'(col_locked), 160'd1);
      for (int l = 40; l < 48; l++) scan_chk("R7", l, 1'b0);

      // R2 unused ops
      issue(3'd1, 8'd17);
      issue(3'd5, 8'd3);
      issue(3'd6, 8'd44);
      issue(3'd7, 8'hFF);
      chk("R2", "page after unused ops", 160'(page_o), 160'd5);
      chk("R2", "col after unused ops", 160'(col_o), 160'd17);
      chk("R2", "mirror after unused ops", 160'(mirror_o), 160'd0);
      scan_chk("R2", 41, 1'b0);

      // R9 mirror
      issue(3'd4, 8'h01);
      chk("R9", "mirror set", 160'(mirror_o), 160'd1);
      scan_chk("R9", 0, 1'b1);
      scan_chk("R9", 17, 1'b1);
      scan_chk("R9", 64, 1'b1);
      issue(3'd0, 8'd0);
      issue(3'd1, 8'd0);
      issue(3'd2, 8'h01);
      model[0][0] = 8'h01;
      chk("R9", "col unaffected", 160'(col_o), 160'd1);
      scan_chk("R9", 0, 1'b1);
      issue(3'd4, 8'h02);
      chk("R9", "mirror clear", 160'(mirror_o), 160'd0);
      scan_chk("R9", 0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule